// File: doc/BRIEF.md
# TLB Invalid-Entry Exception Entry Sequencer

This block captures processor state when an address translation hits a matching entry whose valid flag is clear. The translation unit raises a one-cycle request together with the faulting virtual address, the access direction, and the way that matched. The core supplies its program counter, a delay-slot flag with the address of the owning branch, the live status word and the vector base. On the clock edge that samples the request, the block updates all of the following at once: the page-number part of the entry-high register, the fault-address register, the replacement-counter field, the event-code register, the saved program counter, the saved status and the new status word.

In the cycle after an accepted request, a one-cycle redirect pulse carries the handler fetch address to the front end. A request that arrives while the status word already has its block bit set is refused. Nothing is captured and no redirect is produced. Instead a one-cycle error pulse is raised, and the surrounding core treats it like a reset. Field widths, the page size, the way count and the positions of the three status control bits are parameters.

Top module: `tlb_fault_entry`

## Requirements
- R1: After reset, every captured register, the status output, the redirect address and both pulses read zero.
- R2: An accepted request loads the entry-high output with the faulting address shifted right by PAGE_SHIFT, which is the virtual page number.
- R3: An accepted request loads the fault-address output with the complete faulting virtual address.
- R4: An accepted request loads the replacement-counter output with the failing way number.
- R5: An accepted request loads the event-code output with 0x040 when `acc_store` is 0 (load) and with 0x060 when it is 1 (store).
- R6: An accepted request saves `core_pc` as the saved PC when `in_delay_slot` is 0, and saves `branch_pc` when it is 1.
- R7: An accepted request copies `sr_in` unchanged into the saved-status output.
- R8: An accepted request sets the status output to `sr_in` with bit 30 (mode), bit 29 (register bank) and bit 28 (block) forced to 1 and all other bits kept.
- R9: In the cycle after an accepted request, `redir_valid` is 1 for exactly one cycle and `redir_pc` equals `vbr + 0x100`, truncated to the PC width.
- R10: A request made while `sr_in` bit 28 is 1 changes no captured register, status output or redirect address, gives no redirect pulse, and raises `nest_fault` for exactly the following cycle.
- R11: In a cycle with no request, all captured registers hold and neither pulse is raised in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_req | input | 1 | Invalid-entry exception request, one cycle |
| acc_store | input | 1 | 1 for a store access, 0 for a load |
| miss_va | input | VA_W | Faulting virtual address |
| miss_way | input | log2(WAYS) | Way whose entry matched but was invalid |
| core_pc | input | PC_W | Address of the faulting instruction |
| in_delay_slot | input | 1 | Fault occurred in a delay slot |
| branch_pc | input | PC_W | Address of the delayed branch that owns the slot |
| sr_in | input | SR_W | Current status word |
| vbr | input | PC_W | Vector base |
| ent_vpn | output | VA_W-PAGE_SHIFT | Entry-high page-number field |
| fault_addr | output | VA_W | Fault-address register |
| repl_way | output | log2(WAYS) | Replacement-counter field |
| evt_code | output | 12 | Exception event code |
| saved_pc | output | PC_W | Saved program counter |
| saved_sr | output | SR_W | Saved status |
| sr_out | output | SR_W | Status word after entry |
| redir_valid | output | 1 | One-cycle handler redirect strobe |
| redir_pc | output | PC_W | Handler fetch address |
| nest_fault | output | 1 | One-cycle refusal strobe |

## Verification
The bench builds the block with a 16-bit address and PC, a 10-bit page offset and four ways. The virtual page number is then only six bits wide, and every combination of way, access direction, delay-slot flag and block-bit state can be swept in a few hundred cycles. The 32-bit status word keeps the three forced bits at their real positions, so the bench checks both the forced bits and the bits left alone. A 16-bit vector base near the top of its range lets the addition of 0x100 wrap.

// File: rtl/tlb_fault_pkg.sv
package tlb_fault_pkg;
   localparam int CODE_W = 12;
   localparam logic [CODE_W-1:0] CODE_LOAD_MISS  = 12'h040;
   localparam logic [CODE_W-1:0] CODE_STORE_MISS = 12'h060;

   typedef enum logic {ACC_LOAD = 1'b0, ACC_STORE = 1'b1} acc_dir_e;

   function automatic logic [CODE_W-1:0] miss_code(acc_dir_e dir);
      return (dir == ACC_STORE) ? CODE_STORE_MISS : CODE_LOAD_MISS;
   endfunction
endpackage

// File: rtl/fault_capture.sv
module fault_capture #(
   parameter int VA_W       = 32,
   parameter int PAGE_SHIFT = 10,
   parameter int WAY_W      = 2,
   localparam int VPN_W     = VA_W - PAGE_SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [VA_W-1:0]  va,
   input  logic [WAY_W-1:0] way,
   output logic [VPN_W-1:0] vpn_q,
   output logic [VA_W-1:0]  tea_q,
   output logic [WAY_W-1:0] rc_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vpn_q <= '0;
         tea_q <= '0;
         rc_q  <= '0;
      end else if (take) begin
         vpn_q <= va[VA_W-1:PAGE_SHIFT];
         tea_q <= va;
         rc_q  <= way;
      end
   end
endmodule

// File: rtl/context_save.sv
module context_save
   import tlb_fault_pkg::*;
#(
   parameter int PC_W     = 32,
   parameter int SR_W     = 32,
   parameter bit HAS_SLOT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              store,
   input  logic [PC_W-1:0]   pc,
   input  logic              slot,
   input  logic [PC_W-1:0]   br_pc,
   input  logic [SR_W-1:0]   sr,
   output logic [PC_W-1:0]   spc_q,
   output logic [SR_W-1:0]   ssr_q,
   output logic [CODE_W-1:0] code_q
);
   logic [PC_W-1:0] ret_pc;

   if (HAS_SLOT) begin : g_slot
      assign ret_pc = slot ? br_pc : pc;
   end else begin : g_noslot
      logic unused_slot;
      assign unused_slot = slot ^ (^br_pc);
      assign ret_pc = pc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         spc_q  <= '0;
         ssr_q  <= '0;
         code_q <= '0;
      end else if (take) begin
         spc_q  <= ret_pc;
         ssr_q  <= sr;
         code_q <= miss_code(store ? ACC_STORE : ACC_LOAD);
      end
   end
endmodule

// File: rtl/status_update.sv
module status_update #(
   parameter int SR_W   = 32,
   parameter int MD_BIT = 30,
   parameter int RB_BIT = 29,
   parameter int BL_BIT = 28
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  logic [SR_W-1:0] sr,
   output logic [SR_W-1:0] sr_q
);
   logic [SR_W-1:0] sr_next;

   for (genvar b = 0; b < SR_W; b++) begin : g_bit
      if (b == MD_BIT || b == RB_BIT || b == BL_BIT) begin : g_force
         assign sr_next[b] = 1'b1;
      end else begin : g_keep
         assign sr_next[b] = sr[b];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    sr_q <= '0;
      else if (take) sr_q <= sr_next;
   end
endmodule

// File: rtl/vector_redirect.sv
module vector_redirect #(
   parameter int PC_W    = 32,
   parameter int VEC_OFS = 'h100
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  logic            refuse,
   input  logic [PC_W-1:0] base,
   output logic [PC_W-1:0] tgt_q,
   output logic            valid_q,
   output logic            err_q
);
   localparam logic [PC_W-1:0] OFS = PC_W'(VEC_OFS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_q   <= '0;
         valid_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         valid_q <= take;
         err_q   <= refuse;
         if (take) tgt_q <= base + OFS;
      end
   end
endmodule

// File: rtl/tlb_fault_entry.sv
module tlb_fault_entry
   import tlb_fault_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PAGE_SHIFT = 10,
   parameter int WAYS       = 4,
   parameter int PC_W       = 32,
   parameter int SR_W       = 32,
   parameter int MD_BIT     = 30,
   parameter int RB_BIT     = 29,
   parameter int BL_BIT     = 28,
   parameter int VEC_OFS    = 'h100,
   parameter bit HAS_SLOT   = 1'b1,
   localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int VPN_W     = VA_W - PAGE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_req,
   input  logic              acc_store,
   input  logic [VA_W-1:0]   miss_va,
   input  logic [WAY_W-1:0]  miss_way,
   input  logic [PC_W-1:0]   core_pc,
   input  logic              in_delay_slot,
   input  logic [PC_W-1:0]   branch_pc,
   input  logic [SR_W-1:0]   sr_in,
   input  logic [PC_W-1:0]   vbr,
   output logic [VPN_W-1:0]  ent_vpn,
   output logic [VA_W-1:0]   fault_addr,
   output logic [WAY_W-1:0]  repl_way,
   output logic [CODE_W-1:0] evt_code,
   output logic [PC_W-1:0]   saved_pc,
   output logic [SR_W-1:0]   saved_sr,
   output logic [SR_W-1:0]   sr_out,
   output logic              redir_valid,
   output logic [PC_W-1:0]   redir_pc,
   output logic              nest_fault
);
   if (PAGE_SHIFT < 1 || PAGE_SHIFT >= VA_W) begin : g_bad_page
      $error("PAGE_SHIFT must lie inside the address width");
   end
   if (WAYS < 2) begin : g_bad_ways
      $error("WAYS must be at least 2");
   end
   if (MD_BIT >= SR_W || RB_BIT >= SR_W || BL_BIT >= SR_W) begin : g_bad_bits
      $error("status control bits must lie inside SR_W");
   end
   if (MD_BIT == RB_BIT || MD_BIT == BL_BIT || RB_BIT == BL_BIT) begin : g_dup_bits
      $error("status control bits must be distinct");
   end

   logic blocked_now;
   logic take;
   logic refuse;

   assign blocked_now = sr_in[BL_BIT];
   assign take        = miss_req & ~blocked_now;
   assign refuse      = miss_req & blocked_now;

   fault_capture #(
      .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .WAY_W(WAY_W)
   ) u_cap (
      .clk(clk), .rst_n(rst_n), .take(take), .va(miss_va), .way(miss_way),
      .vpn_q(ent_vpn), .tea_q(fault_addr), .rc_q(repl_way)
   );

   context_save #(
      .PC_W(PC_W), .SR_W(SR_W), .HAS_SLOT(HAS_SLOT)
   ) u_ctx (
      .clk(clk), .rst_n(rst_n), .take(take), .store(acc_store), .pc(core_pc),
      .slot(in_delay_slot), .br_pc(branch_pc), .sr(sr_in),
      .spc_q(saved_pc), .ssr_q(saved_sr), .code_q(evt_code)
   );

   status_update #(
      .SR_W(SR_W), .MD_BIT(MD_BIT), .RB_BIT(RB_BIT), .BL_BIT(BL_BIT)
   ) u_sr (
      .clk(clk), .rst_n(rst_n), .take(take), .sr(sr_in), .sr_q(sr_out)
   );

   vector_redirect #(
      .PC_W(PC_W), .VEC_OFS(VEC_OFS)
   ) u_vec (
      .clk(clk), .rst_n(rst_n), .take(take), .refuse(refuse), .base(vbr),
      .tgt_q(redir_pc), .valid_q(redir_valid), .err_q(nest_fault)
   );
endmodule

// File: rtl/tlb_fault_entry_chk.sv
module tlb_fault_entry_chk
   import tlb_fault_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PAGE_SHIFT = 10,
   parameter int WAY_W      = 2,
   parameter int PC_W       = 32,
   parameter int SR_W       = 32,
   parameter int MD_BIT     = 30,
   parameter int RB_BIT     = 29,
   parameter int BL_BIT     = 28,
   parameter int VEC_OFS    = 'h100
) (
   input logic              clk,
   input logic              rst_n,
   input logic              miss_req,
   input logic              acc_store,
   input logic [VA_W-1:0]   miss_va,
   input logic [WAY_W-1:0]  miss_way,
   input logic [SR_W-1:0]   sr_in,
   input logic [PC_W-1:0]   vbr,
   input logic [VA_W-1:0]   fault_addr,
   input logic [WAY_W-1:0]  repl_way,
   input logic [CODE_W-1:0] evt_code,
   input logic [SR_W-1:0]   saved_sr,
   input logic [SR_W-1:0]   sr_out,
   input logic              redir_valid,
   input logic [PC_W-1:0]   redir_pc,
   input logic              nest_fault
);
   logic acc, ref_q;
   assign acc   = miss_req && !sr_in[BL_BIT];
   assign ref_q = miss_req &&  sr_in[BL_BIT];

   // R3
   tea_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> fault_addr == $past(miss_va));
   // R4
   way_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> repl_way == $past(miss_way));
   // R5
   event_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> evt_code == ($past(acc_store) ? CODE_STORE_MISS : CODE_LOAD_MISS));
   // R7
   ssr_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> saved_sr == $past(sr_in));
   // R8
   sr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> sr_out[MD_BIT] && sr_out[RB_BIT] && sr_out[BL_BIT]);
   // R9
   redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> redir_valid && !nest_fault
              && redir_pc == $past(vbr) + PC_W'(VEC_OFS));
   // R10
   refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_q |=> nest_fault && !redir_valid && $stable(fault_addr)
                && $stable(sr_out) && $stable(saved_sr));
   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !miss_req |=> !redir_valid && !nest_fault && $stable(fault_addr)
                    && $stable(evt_code));
endmodule

bind tlb_fault_entry tlb_fault_entry_chk #(
   .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .WAY_W(WAY_W), .PC_W(PC_W),
   .SR_W(SR_W), .MD_BIT(MD_BIT), .RB_BIT(RB_BIT), .BL_BIT(BL_BIT),
   .VEC_OFS(VEC_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .acc_store(acc_store),
   .miss_va(miss_va), .miss_way(miss_way), .sr_in(sr_in), .vbr(vbr),
   .fault_addr(fault_addr), .repl_way(repl_way), .evt_code(evt_code),
   .saved_sr(saved_sr), .sr_out(sr_out), .redir_valid(redir_valid),
   .redir_pc(redir_pc), .nest_fault(nest_fault)
);

// File: tb/tlb_fault_entry_test.sv
module tlb_fault_entry_test;
   localparam int CLK_PERIOD = 10;
   localparam int VA_W = 16, PSH = 10, WAYS = 4, PC_W = 16, SR_W = 32;
   localparam int WAY_W = 2, VPN_W = VA_W - PSH;

   logic clk = 1'b0, rst_n = 1'b0;
   logic miss_req = 1'b0, acc_store = 1'b0, in_delay_slot = 1'b0;
   logic [VA_W-1:0] miss_va = '0;
   logic [WAY_W-1:0] miss_way = '0;
   logic [PC_W-1:0] core_pc = '0, branch_pc = '0, vbr = '0;
   logic [SR_W-1:0] sr_in = '0;
   logic [VPN_W-1:0] ent_vpn;
   logic [VA_W-1:0] fault_addr;
   logic [WAY_W-1:0] repl_way;
   logic [11:0] evt_code;
   logic [PC_W-1:0] saved_pc, redir_pc;
   logic [SR_W-1:0] saved_sr, sr_out;
   logic redir_valid, nest_fault;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tlb_fault_entry #(.VA_W(VA_W), .PAGE_SHIFT(PSH), .WAYS(WAYS),
                     .PC_W(PC_W), .SR_W(SR_W)) uut (.*);

   // expected model state
   logic [VPN_W-1:0] e_vpn = '0;
   logic [VA_W-1:0] e_tea = '0;
   logic [WAY_W-1:0] e_rc = '0;
   logic [11:0] e_code = '0;
   logic [PC_W-1:0] e_spc = '0, e_tgt = '0;
   logic [SR_W-1:0] e_ssr = '0, e_sr = '0;

   task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic check_regs(input string tag);
      check({"R2 vpn ", tag}, 64'(ent_vpn), 64'(e_vpn));
      check({"R3 tea ", tag}, 64'(fault_addr), 64'(e_tea));
      check({"R4 way ", tag}, 64'(repl_way), 64'(e_rc));
      check({"R5 code ", tag}, 64'(evt_code), 64'(e_code));
      check({"R6 spc ", tag}, 64'(saved_pc), 64'(e_spc));
      check({"R7 ssr ", tag}, 64'(saved_sr), 64'(e_ssr));
      check({"R8 sr ", tag}, 64'(sr_out), 64'(e_sr));
      check({"R9 target ", tag}, 64'(redir_pc), 64'(e_tgt));
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 reset vpn", 64'(ent_vpn), 0);
      check("R1 reset tea", 64'(fault_addr), 0);
      check("R1 reset sr", 64'(sr_out), 0);
      check("R1 reset ssr", 64'(saved_sr), 0);
      check("R1 reset code", 64'(evt_code), 0);
      check("R1 reset spc", 64'(saved_pc), 0);
      check("R1 reset tgt", 64'(redir_pc), 0);
      check("R1 reset pulses", {62'd0, redir_valid, nest_fault}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 64; i++) begin
         logic bl;
         bl = i[0];
         miss_req      = 1'b1;
         acc_store     = i[1];
         in_delay_slot = i[2];
         miss_way      = WAY_W'(i >> 3);
         miss_va       = VA_W'((i * 16'h0B3D) ^ 16'hC5A1);
         core_pc       = PC_W'(16'h2000 + i * 6);
         branch_pc     = PC_W'(16'h2000 + i * 6 - 2);
         vbr           = PC_W'(16'hFF80 - i * 16'h0410);
         sr_in         = (32'h0F0F_00F3 * (i + 1)) & ~(32'h1 << 28);
         if (bl) sr_in = sr_in | (32'h1 << 28);
         if (!bl) begin
            e_vpn  = VPN_W'(miss_va >> PSH);
            e_tea  = miss_va;
            e_rc   = miss_way;
            e_code = acc_store ? 12'h060 : 12'h040;
            e_spc  = in_delay_slot ? branch_pc : core_pc;
            e_ssr  = sr_in;
            e_sr   = sr_in | 32'h7000_0000;
            e_tgt  = PC_W'(vbr + 16'h0100);
         end
         @(negedge clk);
         miss_req = 1'b0;
         check_regs(bl ? "R10 refused" : "accepted");
         check(bl ? "R10 no redirect" : "R9 redirect valid", 64'(redir_valid), 64'(!bl));
         check(bl ? "R10 nest fault" : "R9 no nest fault", 64'(nest_fault), 64'(bl));
         // scramble inputs with no request: nothing may change
         miss_va = ~miss_va; sr_in = ~sr_in; vbr = ~vbr; core_pc = ~core_pc;
         @(negedge clk);
         check("R9/R11 redirect drops", 64'(redir_valid), 0);
         check("R10/R11 nest drops", 64'(nest_fault), 0);
         check_regs("R11 idle");
      end

      // back-to-back accepted requests give continuous valid
      sr_in = 32'h0; vbr = 16'h1000; miss_req = 1'b1; miss_va = 16'hABCD;
      acc_store = 1'b0; in_delay_slot = 1'b0; core_pc = 16'h0042; miss_way = 2'd3;
      @(negedge clk);
      check("R9 first pulse", 64'(redir_valid), 1);
      vbr = 16'h2000;
      @(negedge clk);
      miss_req = 1'b0;
      check("R9 second pulse", 64'(redir_valid), 1);
      check("R9 second target", 64'(redir_pc), 64'h2100);
      @(negedge clk);
      check("R9 pulse ends", 64'(redir_valid), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule